// File: doc/BRIEF.md
# Multi-channel GPIO interrupt generator

This block turns eight general-purpose input pins into interrupt requests. Each channel has a 3-bit trigger code held in one 32-bit configuration word; the code picks whether the channel stays silent, follows a low or high input level, or fires on a falling edge, a rising edge, or either edge. The pins are taken through one register stage. Edges are found by comparing that registered sample with the sample of the clock before.

Edge events land in a sticky per-channel status bit that software clears by writing a one to it. Level triggers drive the status bit straight from the qualified level, so such a bit drops by itself when the level goes away. A single interrupt line, registered, is the OR of all status bits. Rewriting a channel's trigger code drops any pending edge event of that channel and restarts its edge history, so reconfiguration never produces a spurious request.

Top module: `gpio_irq_gen`

## Requirements
- R1: After reset the configuration word reads 0, every status bit is 0 and `irq_out` is 0.
- R2: Channel n's trigger code sits in configuration bits 3n+2..3n (channel 7 in bits 23..21); configuration bits 31..24 ignore writes and read as 0.
- R3: Codes 0 and 1 keep the channel's status bit at 0 whatever its pin does.
- R4: Code 2 makes the status bit equal to the inverted pin, two clock edges after the pin changes, and not sticky.
- R5: Code 3 makes the status bit equal to the pin, two clock edges after the pin changes, and not sticky.
- R6: Code 4 sets the status bit two edges after a 1-to-0 pin change; a 0-to-1 change does not set it; once set it stays set until cleared.
- R7: Code 5 sets the status bit two edges after a 0-to-1 pin change; a 1-to-0 change does not set it.
- R8: Codes 6 and 7 set the status bit on either pin change.
- R9: Asserting `clr_we` with bit n of `clr_mask` at 1 clears a set edge status of channel n on that edge and leaves the other channels unchanged; under codes 2 and 3 the clear has no effect while the level persists.
- R10: When an edge event and a clear of the same channel meet on one clock edge, the status bit ends set.
- R11: `irq_out` equals the OR of all status bits one clock edge earlier.
- R12: A write that changes channel n's code clears its status on that edge, even if an edge event arrives on the same edge, and a pin level held steady across the change raises no event afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| pin_in | input | 8 | Input pins, synchronous to clk |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 8 | Channels to clear (1 = clear) |
| irq_status | output | 8 | Per-channel interrupt status |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The hardest cases are the coincidences: an edge reaching the status register on the very edge that carries a clear, and an edge reaching it on the edge that carries a code change. The stimulus counts the pipeline: it moves the pin, waits one edge so the change sits between the sample and history registers, and then drives the clear or the configuration write for the next edge, where the set must win over the clear but lose to the code change. A pin held high while a channel is off, then switched to rising-edge mode, checks that the reload leaves no false event.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

   localparam int MODE_BITS = 3;

   typedef enum logic [2:0] {
      TRIG_NONE,
      TRIG_LOW,
      TRIG_HIGH,
      TRIG_FALL,
      TRIG_RISE,
      TRIG_ANY
   } trig_e;

   // Code-to-trigger decode; 0/1 alias to off, 6/7 alias to any edge.
   function automatic trig_e decode_trig(input logic [MODE_BITS-1:0] code);
      trig_e t;
      case (code)
         3'd2:          t = TRIG_LOW;
         3'd3:          t = TRIG_HIGH;
         3'd4:          t = TRIG_FALL;
         3'd5:          t = TRIG_RISE;
         3'd6, 3'd7:    t = TRIG_ANY;
         default:       t = TRIG_NONE;
      endcase
      return t;
   endfunction

   function automatic logic is_edge_trig(input trig_e t);
      return (t == TRIG_FALL) || (t == TRIG_RISE) || (t == TRIG_ANY);
   endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
module gpio_irq_cfg
   import gpio_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int REG_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [REG_W-1:0]          wr_data,
   output logic [REG_W-1:0]          rd_data,
   output logic [NUM_CH*MODE_BITS-1:0] codes,
   output logic [NUM_CH-1:0]         code_chg
);
   localparam int USED_W = NUM_CH * MODE_BITS;

   logic [USED_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     code_q <= '0;
      else if (wr_en) code_q <= wr_data[USED_W-1:0];
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chg
      assign code_chg[n] = wr_en &&
         (wr_data[n*MODE_BITS +: MODE_BITS] != code_q[n*MODE_BITS +: MODE_BITS]);
   end

   assign codes = code_q;

   if (USED_W < REG_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[REG_W-1:USED_W];
      assign rd_data   = {{(REG_W-USED_W){1'b0}}, code_q};
   end else begin : g_full
      assign rd_data = code_q;
   end
endmodule

// File: rtl/gpio_irq_chan.sv
`timescale 1ns/1ps
module gpio_irq_chan
   import gpio_irq_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MODE_BITS-1:0] code,
   input  logic                 code_chg,
   input  logic                 pin_s,
   input  logic                 clr,
   output logic                 status
);
   trig_e trig;
   logic  hist_q;
   logic  rise, fall, hit;
   logic  status_q;

   assign trig = decode_trig(code);
   assign rise = pin_s & ~hist_q;
   assign fall = ~pin_s & hist_q;

   always_comb begin
      case (trig)
         TRIG_FALL: hit = fall;
         TRIG_RISE: hit = rise;
         TRIG_ANY:  hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   // History always follows the sample, so a code change restarts it from
   // the current level and no edge is inferred across the change.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= pin_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (code_chg) begin
         status_q <= 1'b0;
      end else begin
         case (trig)
            TRIG_LOW:  status_q <= ~pin_s;
            TRIG_HIGH: status_q <= pin_s;
            TRIG_NONE: status_q <= 1'b0;
            default:   status_q <= (status_q & ~clr) | hit;
         endcase
      end
   end

   assign status = status_q;
endmodule

// File: rtl/gpio_irq_merge.sv
`timescale 1ns/1ps
module gpio_irq_merge #(
   parameter int NUM_CH  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] status,
   output logic              irq
);
   logic any_set;
   assign any_set = |status;

   if (OUT_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_set;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = any_set;
   end
endmodule

// File: rtl/gpio_irq_gen.sv
`timescale 1ns/1ps
module gpio_irq_gen
   import gpio_irq_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int REG_W   = 32,
   parameter bit IN_REG  = 1'b1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic [NUM_CH-1:0] pin_in,
   input  logic              clr_we,
   input  logic [NUM_CH-1:0] clr_mask,
   output logic [NUM_CH-1:0] irq_status,
   output logic              irq_out
);
   localparam int USED_W = NUM_CH * MODE_BITS;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("gpio_irq_gen: NUM_CH must be at least 1");
   end
   if (USED_W > REG_W) begin : g_bad_w
      $error("gpio_irq_gen: configuration word too narrow for NUM_CH codes");
   end

   logic [USED_W-1:0] codes;
   logic [NUM_CH-1:0] code_chg;
   logic [NUM_CH-1:0] pin_s;
   logic [NUM_CH-1:0] clr_v;

   gpio_irq_cfg #(.NUM_CH(NUM_CH), .REG_W(REG_W)) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_data  (cfg_wdata),
      .rd_data  (cfg_rdata),
      .codes    (codes),
      .code_chg (code_chg)
   );

   if (IN_REG) begin : g_in_reg
      logic [NUM_CH-1:0] pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= '0;
         else        pin_q <= pin_in;
      end
      assign pin_s = pin_q;
   end else begin : g_in_direct
      assign pin_s = pin_in;
   end

   assign clr_v = clr_we ? clr_mask : '0;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      gpio_irq_chan i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .code     (codes[n*MODE_BITS +: MODE_BITS]),
         .code_chg (code_chg[n]),
         .pin_s    (pin_s[n]),
         .clr      (clr_v[n]),
         .status   (irq_status[n])
      );
   end

   gpio_irq_merge #(.NUM_CH(NUM_CH), .OUT_REG(OUT_REG)) i_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (irq_status),
      .irq    (irq_out)
   );
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk #(
   parameter int NUM_CH  = 8,
   parameter int REG_W   = 32,
   parameter bit IN_REG  = 1'b1,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [REG_W-1:0]  cfg_wdata,
   input logic [REG_W-1:0]  cfg_rdata,
   input logic [NUM_CH-1:0] pin_in,
   input logic              clr_we,
   input logic [NUM_CH-1:0] clr_mask,
   input logic [NUM_CH-1:0] irq_status,
   input logic              irq_out
);
   localparam int USED_W = NUM_CH * 3;
   localparam logic [REG_W-1:0] USED_MASK = REG_W'((64'd1 << USED_W) - 64'd1);

   // R2: readback after a write shows the used field bits only
   p_cfg_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & USED_MASK)));

   if (OUT_REG) begin : g_or
      // R11: combined output lags the status OR by one edge
      p_irq_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_out == |$past(irq_status)));
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic [2:0] code;
      assign code = cfg_rdata[3*n +: 3];

      // R3: disabled codes never show a status bit
      p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (code < 3'd2) |-> !irq_status[n]);

      // R6: an edge-mode status bit only drops by a clear or a code change
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (code >= 3'd4 && $past(code) == code && $past(irq_status[n]) &&
          !$past(clr_we && clr_mask[n])) |-> irq_status[n]);

      if (IN_REG) begin : g_lvl
         // R4: low-level code follows the inverted pin two edges later
         p_low_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (code == 3'd2 && $past(code) == 3'd2 && $past(rst_n, 2)) |->
            (irq_status[n] == !$past(pin_in[n], 2)));
         // R5: high-level code follows the pin two edges later
         p_high_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (code == 3'd3 && $past(code) == 3'd3 && $past(rst_n, 2)) |->
            (irq_status[n] == $past(pin_in[n], 2)));
      end
   end
endmodule

bind gpio_irq_gen gpio_irq_chk #(
   .NUM_CH (NUM_CH),
   .REG_W  (REG_W),
   .IN_REG (IN_REG),
   .OUT_REG(OUT_REG)
) i_gpio_irq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .pin_in     (pin_in),
   .clr_we     (clr_we),
   .clr_mask   (clr_mask),
   .irq_status (irq_status),
   .irq_out    (irq_out)
);

// File: tb/test_gpio_irq_gen.sv
`timescale 1ns/1ps
module test_gpio_irq_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [7:0]  pin_in = '0;
   logic        clr_we = 1'b0;
   logic [7:0]  clr_mask = '0;
   logic [7:0]  irq_status;
   logic        irq_out;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   logic [23:0] shadow = '0;

   always #2.5 clk = ~clk;

   gpio_irq_gen i_gpio_irq_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pin_in(pin_in), .clr_we(clr_we),
      .clr_mask(clr_mask), .irq_status(irq_status), .irq_out(irq_out)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [31:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic set_mode(input int ch, input logic [2:0] m);
      shadow[3*ch +: 3] = m;
      write_cfg({8'h00, shadow});
   endtask

   task automatic clear(input logic [7:0] m);
      clr_we = 1'b1; clr_mask = m;
      tick(1);
      clr_we = 1'b0; clr_mask = '0;
   endtask

   task automatic t_reset();
      chk("R1 cfg after reset", cfg_rdata, 32'h0);
      chk("R1 status after reset", {24'h0, irq_status}, 32'h0);
      chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
   endtask

   task automatic t_layout();
      write_cfg(32'hFFFF_FFFF);
      chk("R2 upper bits read zero", cfg_rdata, 32'h00FF_FFFF);
      shadow = '0; write_cfg(32'h0);
      set_mode(7, 3'd5);
      chk("R2 channel 7 field at 23..21", cfg_rdata, 32'h00A0_0000);
      pin_in[7] = 1'b1; tick(2);
      chk("R2 R7 rising on channel 7 only", {24'h0, irq_status}, 32'h80);
      clear(8'h80);
      chk("R9 clear channel 7", {24'h0, irq_status}, 32'h0);
      pin_in[7] = 1'b0; tick(3);
      chk("R7 falling ignored", {24'h0, irq_status}, 32'h0);
      set_mode(7, 3'd0);
   endtask

   task automatic t_off();
      set_mode(0, 3'd0); set_mode(1, 3'd1);
      for (int i = 0; i < 6; i++) begin
         pin_in[1:0] = 2'(i + 1); tick(2);
         chk("R3 disabled codes stay quiet", {24'h0, irq_status}, 32'h0);
      end
      chk("R3 irq stays low", {31'h0, irq_out}, 32'h0);
      pin_in[1:0] = 2'b00; tick(3);
   endtask

   task automatic t_level();
      set_mode(2, 3'd2); set_mode(3, 3'd3);
      tick(3);
      chk("R4 R5 level with pins low", {24'h0, irq_status}, 32'h04);
      pin_in[3:2] = 2'b11; tick(1);
      chk("R4 one edge later unchanged", {24'h0, irq_status}, 32'h04);
      tick(1);
      chk("R4 R5 level with pins high", {24'h0, irq_status}, 32'h08);
      pin_in[3:2] = 2'b01; tick(2);
      chk("R5 not sticky", {24'h0, irq_status}, 32'h00);
      pin_in[3] = 1'b1; tick(2);
      clear(8'h08);
      chk("R9 clear ignored in level mode", {24'h0, irq_status}, 32'h08);
      set_mode(2, 3'd0); set_mode(3, 3'd0);
      pin_in[3:2] = 2'b00; tick(3);
      chk("R12 level channels off", {24'h0, irq_status}, 32'h00);
   endtask

   task automatic t_fall();
      set_mode(4, 3'd4);
      pin_in[4] = 1'b1; tick(2);
      chk("R6 rising ignored", {24'h0, irq_status}, 32'h00);
      pin_in[4] = 1'b0; tick(2);
      chk("R6 falling sets", {24'h0, irq_status}, 32'h10);
      chk("R11 irq lags status", {31'h0, irq_out}, 32'h0);
      tick(1);
      chk("R11 irq follows status", {31'h0, irq_out}, 32'h1);
      tick(5);
      chk("R6 status sticky", {24'h0, irq_status}, 32'h10);
      clear(8'h10);
      chk("R9 cleared", {24'h0, irq_status}, 32'h00);
      chk("R11 irq still high one edge", {31'h0, irq_out}, 32'h1);
      tick(1);
      chk("R11 irq drops", {31'h0, irq_out}, 32'h0);
   endtask

   task automatic t_both();
      set_mode(5, 3'd6); set_mode(6, 3'd7);
      pin_in[6:5] = 2'b11; tick(2);
      chk("R8 rising on both codes", {24'h0, irq_status}, 32'h60);
      clear(8'h20);
      chk("R9 partial clear keeps other", {24'h0, irq_status}, 32'h40);
      clear(8'h40);
      pin_in[6:5] = 2'b00; tick(2);
      chk("R8 falling on both codes", {24'h0, irq_status}, 32'h60);
      clear(8'h60);
      set_mode(6, 3'd0);
   endtask

   task automatic t_setwins();
      pin_in[5] = 1'b1; tick(2);
      chk("R8 status set before race", {24'h0, irq_status}, 32'h20);
      pin_in[5] = 1'b0; tick(1);
      clear(8'h20);
      chk("R10 set wins over clear", {24'h0, irq_status}, 32'h20);
      clear(8'h20);
      chk("R10 later clear works", {24'h0, irq_status}, 32'h00);
      set_mode(5, 3'd0);
   endtask

   task automatic t_modechg();
      pin_in[4] = 1'b1; tick(2);
      pin_in[4] = 1'b0; tick(2);
      chk("R6 pending before change", {24'h0, irq_status}, 32'h10);
      set_mode(4, 3'd6);
      chk("R12 change clears pending", {24'h0, irq_status}, 32'h00);
      pin_in[4] = 1'b1; tick(1);
      set_mode(4, 3'd5);
      chk("R12 change beats same-edge event", {24'h0, irq_status}, 32'h00);
      tick(3);
      chk("R12 no late event", {24'h0, irq_status}, 32'h00);
      set_mode(4, 3'd0); pin_in[4] = 1'b0;
      pin_in[1] = 1'b1; tick(3);
      set_mode(1, 3'd5); tick(3);
      chk("R12 steady high gives no edge", {24'h0, irq_status}, 32'h00);
      pin_in[1] = 1'b0; tick(1); pin_in[1] = 1'b1; tick(3);
      chk("R7 real rising after change", {24'h0, irq_status}, 32'h02);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_layout();
      t_off();
      t_level();
      t_fall();
      t_both();
      t_setwins();
      t_modechg();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule